// File: doc/BRIEF.md
# Dual-Edge Pixel Capture with Sync and Control Gating

This block sits at the pixel side of a display-link transmitter. The source drives a pixel bus that is half as wide as the pixel. It places one half of each pixel on the bus around the rising clock edge and the other half around the falling edge. The block joins the two halves into a full pixel word. A select bit sets which half is the low-order one. All outputs are registered and go to a downstream link encoder.

Beside the pixel data, the block carries the data-enable signal and the two sync signals. Each sync signal can be forced low by its own enable bit. The block also builds a four-bit control field for the blanking intervals. Three of those bits come from pins. The fourth comes from a configuration bit, but only when register-configuration mode is active; otherwise that bit is sent high. A power-down control clears every output and holds the capture stage in reset.

All configuration inputs are treated as asynchronous to the pixel clock. Each one passes through a synchronizer before it is used, so a change always takes effect on a rising clock edge.

Top module: `pixcap_gate`

## Requirements
- R1: When the synchronized `hsync_en` is 0, `hsync_out` is 0. When it is 1, `hsync_out` follows `hsync_in` with the pixel latency. After reset the enable reads 1.
- R2: When the synchronized `vsync_en` is 0, `vsync_out` is 0. When it is 1, `vsync_out` follows `vsync_in` with the pixel latency. After reset the enable reads 1.
- R3: The half on `half_bus` at a rising edge is the first half. The half at the following falling edge is the second half. With `hi_first`=0 (the reset value), `pix_out` = {second, first}. With `hi_first`=1, `pix_out` = {first, second}.
- R4: While the synchronized `pwr_on` is 0, every output is 0. After reset `pwr_on` reads 0 until the input has been synchronized.
- R5: While `de_out` is 1, `ctl_out` is 4'b0000.
- R6: While `de_out` is 0, `ctl_out[3:1]` equals the `ctl_pins[2:0]` value that was sampled with the same pixel.
- R7: While `de_out` is 0, `ctl_out[0]` equals `ctl0_bit` when `reg_mode` is 1. It is 1 when `reg_mode` is 0, whatever `ctl0_bit` holds.
- R8: `pix_out`, `de_out`, the syncs and `ctl_out` all update on the rising edge that follows the rising edge that captured the first half. They all belong to the same pixel.
- R9: A change on any configuration input is visible at the outputs no later than the (SYNC_STAGES+1)-th rising edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; both edges capture data |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_bus | input | HALF_W | Half-width pixel data |
| de_in | input | 1 | Data enable, sampled at the rising edge |
| hsync_in | input | 1 | Horizontal sync |
| vsync_in | input | 1 | Vertical sync |
| ctl_pins | input | 3 | Control bits 3..1 |
| reg_mode | input | 1 | Register-configuration mode active |
| hsync_en | input | 1 | Pass horizontal sync (0 forces low) |
| vsync_en | input | 1 | Pass vertical sync (0 forces low) |
| hi_first | input | 1 | First-captured half is the high-order half |
| ctl0_bit | input | 1 | Value for control bit 0 in register mode |
| pwr_on | input | 1 | 0 = powered down, 1 = normal |
| pix_out | output | 2*HALF_W | Rebuilt pixel word |
| de_out | output | 1 | Registered data enable |
| hsync_out | output | 1 | Gated horizontal sync |
| vsync_out | output | 1 | Gated vertical sync |
| ctl_out | output | 4 | Control field for blanking |

## Verification
Each pixel is driven as a first half just after a falling edge and a second half just after the next rising edge. The bench predicts that pixel's outputs at the rising edge after that, one cycle after the first half was taken. It compares them 1 ns after that edge, before the next second half is driven. When a configuration input changes, the bench drives several unchecked pixels, more than SYNC_STAGES+1 edges, before it compares again. One directed check samples a sync output right at the (SYNC_STAGES+1)-th edge after its enable drops.

// File: rtl/pixcap_gate.sv
module pixcap_gate #(
  parameter int HALF_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HALF_W-1:0]   half_bus,
  input  logic                de_in,
  input  logic                hsync_in,
  input  logic                vsync_in,
  input  logic [2:0]          ctl_pins,
  input  logic                reg_mode,
  input  logic                hsync_en,
  input  logic                vsync_en,
  input  logic                hi_first,
  input  logic                ctl0_bit,
  input  logic                pwr_on,
  output logic [2*HALF_W-1:0] pix_out,
  output logic                de_out,
  output logic                hsync_out,
  output logic                vsync_out,
  output logic [3:0]          ctl_out
);
  localparam int PIX_W = 2 * HALF_W;
  localparam int CFG_W = 6;
  // bit order: mode, pwr, ctl0, hi_first, vsync_en, hsync_en
  localparam logic [CFG_W-1:0] CFG_RST = 6'b000011;

  logic [CFG_W-1:0] cfg_sync [SYNC_STAGES];
  logic [CFG_W-1:0] cfg_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) cfg_sync[i] <= CFG_RST;
    end else begin
      cfg_sync[0] <= {reg_mode, pwr_on, ctl0_bit, hi_first, vsync_en, hsync_en};
      for (int i = 1; i < SYNC_STAGES; i++) cfg_sync[i] <= cfg_sync[i-1];
    end
  end

  assign cfg_now = cfg_sync[SYNC_STAGES-1];

  logic hs_en_q, vs_en_q, hi_q, ctl0_q, pwr_q, mode_q;
  assign {mode_q, pwr_q, ctl0_q, hi_q, vs_en_q, hs_en_q} = cfg_now;

  // first half and side-band, rising edge
  logic [HALF_W-1:0] rise_q;
  logic              de_q, hs_q, vs_q;
  logic [2:0]        ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !pwr_q) begin
      rise_q <= '0;
      de_q   <= 1'b0;
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      ctl_q  <= '0;
    end else begin
      rise_q <= half_bus;
      de_q   <= de_in;
      hs_q   <= hsync_in;
      vs_q   <= vsync_in;
      ctl_q  <= ctl_pins;
    end
  end

  // second half, falling edge
  logic [HALF_W-1:0] fall_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)      fall_q <= '0;
    else if (!pwr_q) fall_q <= '0;
    else             fall_q <= half_bus;
  end

  // output stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !pwr_q) begin
      pix_out   <= '0;
      de_out    <= 1'b0;
      hsync_out <= 1'b0;
      vsync_out <= 1'b0;
      ctl_out   <= '0;
    end else begin
      pix_out   <= hi_q ? {rise_q, fall_q} : {fall_q, rise_q};
      de_out    <= de_q;
      hsync_out <= hs_q & hs_en_q;
      vsync_out <= vs_q & vs_en_q;
      ctl_out   <= de_q ? 4'b0000 : {ctl_q, (mode_q ? ctl0_q : 1'b1)};
    end
  end

  a_r1_hs_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_en_q |=> !hsync_out);
  a_r2_vs_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_en_q |=> !vsync_out);
  a_r3_low_half_order: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_q && !hi_q) |=> pix_out[HALF_W-1:0] == $past(rise_q));
  a_r4_pd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_q |=> (pix_out == '0 && !de_out && !hsync_out && !vsync_out && ctl_out == '0));
  a_r5_ctl_quiet_active: assert property (@(posedge clk) disable iff (!rst_n)
    de_out |-> ctl_out == 4'b0000);
  a_r6_ctl_pins_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_q && !de_q) |=> ctl_out[3:1] == $past(ctl_q));
  a_r7_ctl0_high_free: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_q && !mode_q && !de_q) |=> ctl_out[0]);
  a_r8_de_align: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_q |=> de_out == $past(de_q));

  initial assert (PIX_W == 2 * HALF_W && SYNC_STAGES >= 1);
endmodule

// File: tb/test_pixcap_gate.sv
module test_pixcap_gate;
  localparam int HW = 12;
  localparam int SS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [HW-1:0] half_bus = '0;
  logic de_in = 0, hsync_in = 0, vsync_in = 0;
  logic [2:0] ctl_pins = '0;
  logic reg_mode = 0, hsync_en = 1, vsync_en = 1, hi_first = 0, ctl0_bit = 0, pwr_on = 0;
  logic [2*HW-1:0] pix_out;
  logic de_out, hsync_out, vsync_out;
  logic [3:0] ctl_out;

  int n_cmp = 0, n_bad = 0;

  pixcap_gate #(.HALF_W(HW), .SYNC_STAGES(SS)) i_pixcap_gate (
    .clk(clk), .rst_n(rst_n), .half_bus(half_bus), .de_in(de_in),
    .hsync_in(hsync_in), .vsync_in(vsync_in), .ctl_pins(ctl_pins),
    .reg_mode(reg_mode), .hsync_en(hsync_en), .vsync_en(vsync_en),
    .hi_first(hi_first), .ctl0_bit(ctl0_bit), .pwr_on(pwr_on),
    .pix_out(pix_out), .de_out(de_out), .hsync_out(hsync_out),
    .vsync_out(vsync_out), .ctl_out(ctl_out));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2*HW-1:0] exp_pix(input logic [HW-1:0] a, input logic [HW-1:0] b, input logic hi);
    return hi ? {a, b} : {b, a};
  endfunction

  function automatic logic [3:0] exp_ctl(input logic de, input logic [2:0] p, input logic md, input logic c0);
    return de ? 4'b0000 : {p, (md ? c0 : 1'b1)};
  endfunction

  // pending expectation from previous pixel
  logic pv = 0;
  logic [2*HW-1:0] e_pix;
  logic e_de, e_hs, e_vs;
  logic [3:0] e_ctl;

  task automatic pixel(input logic [HW-1:0] a, input logic [HW-1:0] b, input logic de,
                       input logic hs, input logic vs, input logic [2:0] p, input logic check);
    @(negedge clk); #1;
    half_bus = a; de_in = de; hsync_in = hs; vsync_in = vs; ctl_pins = p;
    @(posedge clk); #1;
    if (pv) begin
      chk("R3/R8 pix", 32'(pix_out), 32'(e_pix));
      chk("R8 de", 32'(de_out), 32'(e_de));
      chk("R1 hsync", 32'(hsync_out), 32'(e_hs));
      chk("R2 vsync", 32'(vsync_out), 32'(e_vs));
      chk("R5/R6/R7 ctl", 32'(ctl_out), 32'(e_ctl));
    end
    half_bus = b;
    pv = check;
    if (!pwr_on) begin
      e_pix = '0; e_de = 0; e_hs = 0; e_vs = 0; e_ctl = '0;
    end else begin
      e_pix = exp_pix(a, b, hi_first);
      e_de = de; e_hs = hs & hsync_en; e_vs = vs & vsync_en;
      e_ctl = exp_ctl(de, p, reg_mode, ctl0_bit);
    end
  endtask

  task automatic settle();
    for (int i = 0; i < SS + 3; i++) pixel('0, '0, 0, 0, 0, '0, 0);
  endtask

  task automatic rnd_block(input int n);
    for (int i = 0; i < n; i++)
      pixel(HW'($urandom), HW'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom), 1);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(777));
    #20; rst_n = 1;
    @(posedge clk); #1;
    // R4 reset state: powered down, all zero
    chk("R4 reset pix", 32'(pix_out), 0);
    chk("R4 reset ctl", 32'(ctl_out), 0);
    chk("R4 reset syncs", 32'({de_out, hsync_out, vsync_out}), 0);
    pwr_on = 1;
    settle();
    // R1/R2 reset default enables, R3 default order, R7 non-register mode
    pixel(12'hABC, 12'h123, 0, 1, 1, 3'b101, 1);
    pixel(12'h0F0, 12'hF0F, 1, 1, 1, 3'b111, 1);
    pixel(12'h000, 12'h000, 0, 0, 0, 3'b000, 1);
    rnd_block(150);
    // R3 high half first
    hi_first = 1; settle(); rnd_block(150);
    // R1/R2 forced low, R9 timing on hsync
    pixel('0, '0, 0, 1, 1, '0, 0);
    @(negedge clk); #1; hsync_in = 1; hsync_en = 0;
    repeat (SS + 1) @(posedge clk);
    #1; chk("R9 hsync_en latency", 32'(hsync_out), 0);
    pv = 0;
    vsync_en = 0; settle(); rnd_block(150);
    // R7 register mode, ctl0 both values
    hsync_en = 1; vsync_en = 1; reg_mode = 1; ctl0_bit = 0; settle();
    pixel(12'h555, 12'hAAA, 0, 0, 0, 3'b010, 1);
    rnd_block(100);
    ctl0_bit = 1; settle(); rnd_block(100);
    // R7 ctl0 ignored outside register mode
    reg_mode = 0; ctl0_bit = 0; settle(); rnd_block(100);
    // R4 power down mid-stream
    pwr_on = 0; settle(); rnd_block(50);
    pwr_on = 1; hi_first = 0; settle(); rnd_block(100);
    pixel('0, '0, 0, 0, 0, '0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule